// File: doc/BRIEF.md
# CAN Receive Frame Ring FIFO

This block holds received CAN frames in a small byte ring until software collects them. Every frame becomes a variable-length record: three header bytes followed by as many data bytes as the frame carries, up to eight. Records are packed one behind the other with no gaps, and a record may run past the last byte of the ring and continue at address 0. A frame is accepted only as a whole. When the free space is smaller than the record, the frame is dropped: nothing is written, nothing is counted, and a sticky overrun flag with its interrupt line is set.

The write side takes one complete frame in a single cycle. The read side shows the oldest record through a byte window addressed by an offset from the record start. The window hides the wrap point, so a wrapped record reads as contiguous bytes. A release command discards the oldest record. A message count and a frame-available flag tell the reader how much is pending.

Top module: `can_rx_ring`

## Requirements
- R1: After reset, msg_count is 0 and frame_avail, overrun and ovr_irq are all low.
- R2: An accepted frame raises msg_count by one at the next clock edge, and frame_avail is then high.
- R3: A record is laid out as follows. Offsets 0, 1 and 2 hold wr_hdr[7:0], wr_hdr[15:8] and wr_hdr[23:16]. Data byte k (wr_data[8k+7:8k]) is at offset 3+k. The data length code is wr_hdr[3:0]. rd_byte shows, without a clock, the byte of the oldest record at offset rd_off.
- R4: A data length code above 8 counts as 8. The record then takes 11 bytes, and no data byte beyond the eighth is stored.
- R5: A frame whose record size exceeds the free space (64 minus bytes in use) is dropped. msg_count does not change, and overrun and ovr_irq are high after the next edge.
- R6: A dropped frame writes no byte. The stored records and the free space are the same as before the drop.
- R7: A record that crosses the end of the ring reads through rd_off 0 to size-1 as one contiguous record.
- R8: A release with a frame pending advances to the next record and lowers msg_count by one. A release with msg_count at 0 has no effect.
- R9: clr_ovr clears overrun and ovr_irq and leaves the stored records alone. If a drop happens in the same cycle, the drop wins.
- R10: A write and a release in the same cycle both take effect. The fit is judged on the free space as it stood before that release.
- R11: A frame whose size equals the free space exactly is accepted, and the ring can hold all 64 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Offers one complete frame this cycle |
| wr_hdr | input | 24 | Three header bytes; bits 3:0 are the data length code |
| wr_data | input | 64 | Data bytes, byte k in bits 8k+7:8k |
| rd_off | input | 4 | Byte offset into the oldest record |
| rd_byte | output | 8 | Byte of the oldest record at rd_off |
| rel_req | input | 1 | Release the oldest record |
| clr_ovr | input | 1 | Clear the overrun flag and interrupt |
| msg_count | output | 7 | Number of complete records stored |
| frame_avail | output | 1 | High while at least one record is pending |
| overrun | output | 1 | Sticky flag: a frame was dropped |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
A wrong byte count or read pointer does not show at once. It shows one release later, when the window starts in the middle of a record and the header bytes read back out of place. It also shows when a frame that should fit is dropped, or one that should not is taken. For this reason the bench fills the ring to the exact byte and reads every record back after each release, so that a drift of even one byte fails at the next record it reaches. A miscounted message counter shows at the next edge on msg_count and frame_avail.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;
  localparam int HDR_BYTES = 3;
  localparam int MAX_DATA  = 8;
  localparam int DLC_W     = 4;
  localparam int REC_MAX   = HDR_BYTES + MAX_DATA;
  localparam int LEN_W     = $clog2(REC_MAX + 1);

  // Record size in bytes for a data length code, code clamped to MAX_DATA.
  function automatic logic [LEN_W-1:0] rec_size(input logic [DLC_W-1:0] dlc);
    logic [DLC_W-1:0] eff;
    eff = (dlc > DLC_W'(MAX_DATA)) ? DLC_W'(MAX_DATA) : dlc;
    return LEN_W'(HDR_BYTES) + LEN_W'(eff);
  endfunction
endpackage

// File: rtl/can_rxf_store.sv
module can_rxf_store
  import can_rxf_pkg::*;
#(
  parameter int RING_BYTES = 64,
  localparam int PTR_W = $clog2(RING_BYTES)
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [PTR_W-1:0]       wr_base,
  input  logic [LEN_W-1:0]       wr_len,
  input  logic [REC_MAX*8-1:0]   wr_rec,
  input  logic [PTR_W-1:0]       rd_base,
  input  logic [LEN_W-1:0]       rd_off,
  output logic [7:0]             rd_byte,
  output logic [7:0]             head_byte
);
  localparam int SLOTS = 2 ** LEN_W;

  logic [7:0] rec_b [SLOTS];
  logic [7:0] ring  [RING_BYTES];

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      rec_b[i] = (i < REC_MAX) ? wr_rec[(i % REC_MAX)*8 +: 8] : 8'h00;
    end
  end

  for (genvar a = 0; a < RING_BYTES; a++) begin : g_cell
    logic [PTR_W-1:0] rel;
    logic             cell_we;
    logic [7:0]       cell_d;
    logic [7:0]       cell_q;

    always_comb begin
      rel     = PTR_W'(a) - wr_base;
      cell_we = wr_en && (rel < PTR_W'(wr_len));
      cell_d  = rec_b[rel[LEN_W-1:0]];
    end

    always_ff @(posedge clk) begin
      if (cell_we) cell_q <= cell_d;
    end

    assign ring[a] = cell_q;
  end

  assign rd_byte   = ring[rd_base + PTR_W'(rd_off)];
  assign head_byte = ring[rd_base];
endmodule

// File: rtl/can_rxf_ctrl.sv
module can_rxf_ctrl
  import can_rxf_pkg::*;
#(
  parameter int RING_BYTES = 64,
  localparam int PTR_W = $clog2(RING_BYTES),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [DLC_W-1:0] wr_dlc,
  input  logic             rel_req,
  input  logic             clr_ovr,
  input  logic [DLC_W-1:0] head_dlc,
  output logic             wr_ok,
  output logic             rel_ok,
  output logic [LEN_W-1:0] wr_len,
  output logic [PTR_W-1:0] wr_ptr_q,
  output logic [PTR_W-1:0] rd_ptr_q,
  output logic [CNT_W-1:0] used_q,
  output logic [CNT_W-1:0] msg_q,
  output logic             ovr_q
);
  logic [LEN_W-1:0] rd_len;
  logic [CNT_W-1:0] free_bytes;
  logic [PTR_W-1:0] wr_ptr_d, rd_ptr_d;
  logic [CNT_W-1:0] used_d, msg_d;
  logic             ovr_d, cnt_en;

  always_comb begin
    wr_len     = rec_size(wr_dlc);
    rd_len     = rec_size(head_dlc);
    free_bytes = CNT_W'(RING_BYTES) - used_q;
    wr_ok      = wr_valid && (CNT_W'(wr_len) <= free_bytes);
    rel_ok     = rel_req && (msg_q != '0);
    cnt_en     = wr_ok || rel_ok;
    wr_ptr_d   = wr_ptr_q + PTR_W'(wr_len);
    rd_ptr_d   = rd_ptr_q + PTR_W'(rd_len);
    used_d     = used_q + (wr_ok ? CNT_W'(wr_len) : '0)
                        - (rel_ok ? CNT_W'(rd_len) : '0);
    msg_d      = msg_q + (wr_ok ? CNT_W'(1) : '0) - (rel_ok ? CNT_W'(1) : '0);
    if (wr_valid && !wr_ok) ovr_d = 1'b1;
    else if (clr_ovr)       ovr_d = 1'b0;
    else                    ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      used_q   <= '0;
      msg_q    <= '0;
      ovr_q    <= 1'b0;
    end else begin
      if (wr_ok)  wr_ptr_q <= wr_ptr_d;
      if (rel_ok) rd_ptr_q <= rd_ptr_d;
      if (cnt_en) begin
        used_q <= used_d;
        msg_q  <= msg_d;
      end
      ovr_q <= ovr_d;
    end
  end
endmodule

// File: rtl/can_rx_ring.sv
module can_rx_ring
  import can_rxf_pkg::*;
#(
  parameter int RING_BYTES = 64,
  localparam int PTR_W = $clog2(RING_BYTES),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  input  logic [HDR_BYTES*8-1:0]  wr_hdr,
  input  logic [MAX_DATA*8-1:0]   wr_data,
  input  logic [LEN_W-1:0]        rd_off,
  output logic [7:0]              rd_byte,
  input  logic                    rel_req,
  input  logic                    clr_ovr,
  output logic [CNT_W-1:0]        msg_count,
  output logic                    frame_avail,
  output logic                    overrun,
  output logic                    ovr_irq
);
  logic             wr_ok, rel_ok, ovr_q;
  logic [LEN_W-1:0] wr_len;
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] used_q, msg_q;
  logic [7:0]       head_byte;

  can_rxf_ctrl #(.RING_BYTES(RING_BYTES)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_dlc   (wr_hdr[DLC_W-1:0]),
    .rel_req  (rel_req),
    .clr_ovr  (clr_ovr),
    .head_dlc (head_byte[DLC_W-1:0]),
    .wr_ok    (wr_ok),
    .rel_ok   (rel_ok),
    .wr_len   (wr_len),
    .wr_ptr_q (wr_ptr_q),
    .rd_ptr_q (rd_ptr_q),
    .used_q   (used_q),
    .msg_q    (msg_q),
    .ovr_q    (ovr_q)
  );

  can_rxf_store #(.RING_BYTES(RING_BYTES)) store_i (
    .clk       (clk),
    .wr_en     (wr_ok),
    .wr_base   (wr_ptr_q),
    .wr_len    (wr_len),
    .wr_rec    ({wr_data, wr_hdr}),
    .rd_base   (rd_ptr_q),
    .rd_off    (rd_off),
    .rd_byte   (rd_byte),
    .head_byte (head_byte)
  );

  assign msg_count   = msg_q;
  assign frame_avail = (msg_q != '0);
  assign overrun     = ovr_q;
  assign ovr_irq     = ovr_q;
endmodule

// File: rtl/can_rx_ring_chk.sv
module can_rx_ring_chk #(
  parameter int RING_BYTES = 64,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             rel_req,
  input logic             clr_ovr,
  input logic             wr_ok,
  input logic             rel_ok,
  input logic [CNT_W-1:0] msg_count,
  input logic [CNT_W-1:0] used_bytes,
  input logic             frame_avail,
  input logic             overrun,
  input logic             ovr_irq
);
  assert_accept_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !rel_ok) |=> (msg_count == $past(msg_count) + 1'b1) && frame_avail);

  assert_drop_no_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ok && !rel_ok) |=> (msg_count == $past(msg_count)) && overrun && ovr_irq);

  assert_release_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && msg_count == '0 && !wr_valid) |=> (msg_count == '0) && $stable(used_bytes));

  assert_release_dec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_ok && !wr_ok) |=> msg_count == $past(msg_count) - 1'b1);

  assert_empty_ring_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_count == '0) |-> (used_bytes == '0) && !frame_avail);

  assert_clear_ovr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovr && !(wr_valid && !wr_ok)) |=> !overrun && !ovr_irq);

  assert_both_sides_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && rel_ok) |=> $stable(msg_count));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    used_bytes <= CNT_W'(RING_BYTES));
endmodule

bind can_rx_ring can_rx_ring_chk #(.RING_BYTES(RING_BYTES), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .rel_req     (rel_req),
  .clr_ovr     (clr_ovr),
  .wr_ok       (wr_ok),
  .rel_ok      (rel_ok),
  .msg_count   (msg_count),
  .used_bytes  (used_q),
  .frame_avail (frame_avail),
  .overrun     (overrun),
  .ovr_irq     (ovr_irq)
);

// File: tb/can_rx_ring_tb_top.sv
module can_rx_ring_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RING = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid, rel_req, clr_ovr;
  logic [23:0] wr_hdr;
  logic [63:0] wr_data;
  logic [3:0]  rd_off;
  logic [7:0]  rd_byte;
  logic [6:0]  msg_count;
  logic        frame_avail, overrun, ovr_irq;

  int checks = 0;
  int errors = 0;
  byte unsigned exp_q[$];
  int          len_q[$];
  bit          exp_ovr;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_rx_ring dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_hdr(wr_hdr),
    .wr_data(wr_data), .rd_off(rd_off), .rd_byte(rd_byte), .rel_req(rel_req),
    .clr_ovr(clr_ovr), .msg_count(msg_count), .frame_avail(frame_avail),
    .overrun(overrun), .ovr_irq(ovr_irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int rsize(input int dlc);
    return 3 + ((dlc > 8) ? 8 : dlc);
  endfunction

  function automatic logic [63:0] pattern(input int seed);
    logic [63:0] d;
    for (int k = 0; k < 8; k++) d[k*8 +: 8] = 8'(seed + k * 17);
    return d;
  endfunction

  // Driver: updates the expected queue, then applies one cycle of stimulus.
  task automatic cycle(input bit w, input logic [23:0] hdr, input logic [63:0] d,
                       input bit r, input bit c);
    int n;
    bit fit;
    fit = w && (rsize(int'(hdr[3:0])) <= RING - exp_q.size());
    if (w && !fit) exp_ovr = 1'b1;
    else if (c)    exp_ovr = 1'b0;
    if (r && len_q.size() > 0) begin
      n = len_q.pop_front();
      for (int i = 0; i < n; i++) void'(exp_q.pop_front());
    end
    if (fit) begin
      n = rsize(int'(hdr[3:0]));
      for (int i = 0; i < 3; i++) exp_q.push_back(hdr[i*8 +: 8]);
      for (int i = 3; i < n; i++) exp_q.push_back(d[(i-3)*8 +: 8]);
      len_q.push_back(n);
    end
    @(negedge clk);
    wr_valid = w; wr_hdr = hdr; wr_data = d; rel_req = r; clr_ovr = c;
    @(negedge clk);
    wr_valid = 1'b0; rel_req = 1'b0; clr_ovr = 1'b0;
  endtask

  task automatic put(input int dlc, input int seed);
    cycle(1'b1, {8'(seed), 8'(seed ^ 8'h5a), 4'(seed), 4'(dlc)}, pattern(seed), 1'b0, 1'b0);
  endtask

  task automatic check_status(input string req);
    chk(req, "msg_count", int'(msg_count), len_q.size());
    chk(req, "frame_avail", int'(frame_avail), int'(len_q.size() > 0));
    chk(req, "overrun", int'(overrun), int'(exp_ovr));
    chk(req, "ovr_irq", int'(ovr_irq), int'(exp_ovr));
  endtask

  // Monitor: compares the oldest record through the read window.
  task automatic check_oldest(input string req);
    if (len_q.size() == 0) return;
    for (int o = 0; o < len_q[0]; o++) begin
      rd_off = 4'(o);
      #1;
      chk(req, $sformatf("rd_byte[%0d]", o), int'(rd_byte), int'(exp_q[o]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; rel_req = 1'b0; clr_ovr = 1'b0;
    wr_hdr = '0; wr_data = '0; rd_off = '0; exp_ovr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_status("R1");

    cycle(1'b0, '0, '0, 1'b1, 1'b0);       // release on empty ring
    check_status("R8");

    put(3, 8'h10);                          // A: 6 bytes at 0..5
    check_status("R2");
    check_oldest("R3");
    for (int f = 0; f < 5; f++) put(8, 8'h20 + f * 8'h10);   // B..F: 61 bytes used
    check_status("R2");

    put(8, 8'h90);                          // 11 > 3 free: dropped
    check_status("R5");
    check_oldest("R6");
    cycle(1'b0, '0, '0, 1'b0, 1'b1);       // clear overrun
    check_status("R9");
    check_oldest("R9");

    cycle(1'b0, '0, '0, 1'b1, 1'b0);       // release A
    check_status("R8");
    check_oldest("R8");
    cycle(1'b0, '0, '0, 1'b1, 1'b0);       // release B: 44 used, write at 61
    check_oldest("R8");

    put(15, 8'ha0);                         // J: clamped to 11, wraps 61..7
    check_status("R4");
    put(6, 8'hb0);                          // K: 9 bytes fits exactly
    check_status("R11");
    put(0, 8'hc0);                          // no space at all: dropped
    check_status("R6");

    cycle(1'b0, '0, '0, 1'b1, 1'b1);       // release C, clear overrun
    check_status("R9");
    cycle(1'b1, {8'h77, 8'h66, 8'h55, 4'h0, 4'd8}, pattern(8'hd0), 1'b1, 1'b0);
    check_status("R10");

    while (len_q.size() > 0) begin
      check_oldest((exp_q[0] == 8'h0f) ? "R7" : "R3");
      cycle(1'b0, '0, '0, 1'b1, 1'b0);
      check_status("R8");
    end
    cycle(1'b0, '0, '0, 1'b1, 1'b0);
    check_status("R8");

    put(2, 8'he0);
    check_oldest("R3");
    check_status("R2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule